// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block holds the bus-visible registers that feed four 12-bit digital-to-analog converters. Software writes a code for each channel into a shadow register and a range word into a shared shadow control register. In buffered mode nothing reaches the converter outputs until software reads a dedicated strobe address. A read of the data-update address moves all four shadow codes into the active registers on the same clock edge, so every channel changes together. A separate read of the range-update address commits the shadow range word.

A mode register enables the outputs and selects buffered or direct operation. In direct mode, a data write reaches the addressed channel's active register on the next clock and needs no strobe. The range word always waits for its strobe. While the outputs are disabled, every code output reads zero. The active registers keep their contents, so the previous codes come back when the outputs are enabled again. The active registers are the block's outputs. Serialising them to the converters happens elsewhere.

Top module: `dac_shadow_bank`

## Requirements
- R1: A synchronous active-low reset clears the mode register, all shadow and active code registers, and both range registers, so every output is zero. A data-update read issued after reset with no intervening data write leaves the codes at zero.
- R2: With the mode register set to enabled and buffered (bits 1 and 0 both 1), a data write changes no code output.
- R3: A read of word address 2 copies all four shadow codes into the active registers on one clock edge, and all four outputs show the new codes in the following cycle.
- R4: With the outputs enabled and buffered mode off (mode value 2), a write to a channel's data address changes that channel's code output one clock later and leaves the other three channels unchanged.
- R5: Bits 15:12 of a data write are discarded. Only bits 11:0 become the channel code.
- R6: A write to the range word (word address 1) changes no range output until a read of word address 1. A data-update read does not commit the range word, and a range-update read does not commit data.
- R7: In the committed range word, bits 7, 6, 5 and 4 give the bipolar flag (1 = bipolar) of channels A, B, C and D, and bits 11, 10, 9 and 8 give the gain flag of channels A, B, C and D. On the output vectors, bit 0 is channel A and bit 3 is channel D.
- R8: While mode bit 1 is 0, all four code outputs are zero. The range outputs are not affected. Writes made while disabled still update the active registers, and those codes appear once the outputs are enabled.
- R9: Word address 0 is the mode register (bit 1 enable, bit 0 buffered). Word address 1 is the range word, and a read of it commits the range. A read of word address 2 commits data. Data registers for channels A to D sit at word addresses 4 to 7. Reads of any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (commit triggers) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| dac_code_o | output | 48 | Active codes, channel A in bits 11:0 up to channel D in bits 47:36 |
| dac_bipolar_o | output | 4 | Committed bipolar flags, bit 0 = channel A |
| dac_gain_o | output | 4 | Committed gain flags, bit 0 = channel A |

## Verification
The hardest state to reach is one where the shadow and active registers disagree on several channels while the mode changes underneath them. An example is a code written while the outputs are disabled in direct mode, followed by a later switch back to buffered operation with fresh shadow values pending. The stimulus table walks through that sequence. It loads all four shadows before one commit, changes mode between data writes, and writes a channel while disabled before re-enabling. At each step it checks that only the intended strobe moved each output. Directed tests then reset mid-run and show that no stale shadow survives a later commit.

// File: rtl/dacbank_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the DAC register bank.
// Assumes word addressing on a 16-bit bus.
package dacbank_pkg;
    localparam int NUM_CH    = 4;
    localparam int CODE_W    = 12;
    localparam int BUS_W     = 16;
    localparam int ADDR_W    = 4;

    // Word address map
    localparam int ADR_MODE      = 0;
    localparam int ADR_RANGE     = 1;
    localparam int ADR_DATA_UPD  = 2;
    localparam int ADR_DATA_BASE = 4;

    // Mode register bits
    localparam int MODE_EN_BIT  = 1;
    localparam int MODE_BUF_BIT = 0;

    // Range word: channel A at the top bit of each field, later channels below
    localparam int RNG_POL_TOP  = 7;
    localparam int RNG_GAIN_TOP = 11;

    typedef struct packed {
        logic mode_wr;
        logic rng_wr;
        logic rng_upd;
        logic data_upd;
    } strobe_t;
endpackage

// File: rtl/dacbank_decode.sv
`timescale 1ns/1ps
// Module: dacbank_decode
// Turns bus strobes and a word address into per-register strobes.
// Assumes at most one of wr_en / rd_en is high in a cycle.
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W
) (
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    output strobe_t        st,
    output logic [NCH-1:0] data_wr
);
    // Register-level strobes
    always_comb begin
        st.mode_wr  = wr_en && (int'(addr) == ADR_MODE);
        st.rng_wr   = wr_en && (int'(addr) == ADR_RANGE);
        st.rng_upd  = rd_en && (int'(addr) == ADR_RANGE);
        st.data_upd = rd_en && (int'(addr) == ADR_DATA_UPD);
    end

    // One data-write strobe per channel at consecutive addresses
    for (genvar i = 0; i < NCH; i++) begin : g_wr
        assign data_wr[i] = wr_en && (int'(addr) == ADR_DATA_BASE + i);
    end
endmodule

// File: rtl/dacbank_channel.sv
`timescale 1ns/1ps
// Module: dacbank_channel
// Shadow and active code registers for one converter channel.
// Assumes write and commit strobes are single-cycle pulses.
module dacbank_channel #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wcode,
    input  logic          upd,
    input  logic          buffered,
    output logic [CW-1:0] active
);
    logic [CW-1:0] shadow_q;

    // Shadow captures every write; active follows the write directly or the commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active   <= '0;
        end else begin
            if (wr) shadow_q <= wcode;
            if (wr && !buffered) active <= wcode;
            else if (upd)        active <= shadow_q;
        end
    end
endmodule

// File: rtl/dacbank_range.sv
`timescale 1ns/1ps
// Module: dacbank_range
// Shadow and active range word shared by all channels, plus the flag decode.
// Assumes the field slice given on rng_in spans the gain and bipolar fields.
module dacbank_range
    import dacbank_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [RNG_GAIN_TOP:RNG_POL_TOP-NCH+1] rng_in,
    input  logic           upd,
    output logic [NCH-1:0] bipolar,
    output logic [NCH-1:0] gain
);
    localparam int LO = RNG_POL_TOP - NCH + 1;
    localparam int RW = RNG_GAIN_TOP - LO + 1;

    logic [RW-1:0] shadow_q;
    logic [RW-1:0] active_q;

    // Range word commits only on its own strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr)  shadow_q <= rng_in;
            if (upd) active_q <= shadow_q;
        end
    end

    // Channel i takes the bit i places below each field's top bit
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign bipolar[i] = active_q[RNG_POL_TOP - i - LO];
        assign gain[i]    = active_q[RNG_GAIN_TOP - i - LO];
    end
endmodule

// File: rtl/dac_shadow_bank.sv
`timescale 1ns/1ps
// Module: dac_shadow_bank (top)
// Bus-side register bank for four converter channels: mode register,
// per-channel shadow/active codes, shared range word, read-triggered commits.
// Assumes single-cycle bus strobes and synchronous active-low reset.
module dac_shadow_bank
    import dacbank_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CODE_W,
    parameter int BW  = BUS_W,
    parameter int AW  = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [NCH*CW-1:0] dac_code_o,
    output logic [NCH-1:0]  dac_bipolar_o,
    output logic [NCH-1:0]  dac_gain_o
);
    strobe_t        st;
    logic [NCH-1:0] data_wr;
    logic           en_q;
    logic           buf_q;
    logic           unused_hi_bits;

    assign unused_hi_bits = ^bus_wdata[BW-1:RNG_GAIN_TOP+1];

    dacbank_decode #(.NCH(NCH), .AW(AW)) i_decode (
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .st      (st),
        .data_wr (data_wr)
    );

    // Mode register: output enable and buffered selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            buf_q <= 1'b0;
        end else if (st.mode_wr) begin
            en_q  <= bus_wdata[MODE_EN_BIT];
            buf_q <= bus_wdata[MODE_BUF_BIT];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CW-1:0] act;
        dacbank_channel #(.CW(CW)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (data_wr[i]),
            .wcode    (bus_wdata[CW-1:0]),
            .upd      (st.data_upd),
            .buffered (buf_q),
            .active   (act)
        );
        // Disabled outputs read zero; the active register is kept
        assign dac_code_o[i*CW +: CW] = en_q ? act : '0;
    end

    dacbank_range #(.NCH(NCH)) i_range (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (st.rng_wr),
        .rng_in  (bus_wdata[RNG_GAIN_TOP:RNG_POL_TOP-NCH+1]),
        .upd     (st.rng_upd),
        .bipolar (dac_bipolar_o),
        .gain    (dac_gain_o)
    );
endmodule

// File: rtl/dacbank_chk.sv
`timescale 1ns/1ps
// Module: dacbank_chk
// Temporal checks on the register bank, bound to the top module.
module dacbank_chk
    import dacbank_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CODE_W,
    parameter int BW  = BUS_W,
    parameter int AW  = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input logic [BW-1:0]     bus_wdata,
    input logic [NCH*CW-1:0] dac_code_o,
    input logic [NCH-1:0]    dac_bipolar_o,
    input logic [NCH-1:0]    dac_gain_o,
    input logic              en_q,
    input logic              buf_q
);
    // R1: first cycle out of reset shows all-zero outputs
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_code_o == '0 && dac_bipolar_o == '0 && dac_gain_o == '0));

    // R2: buffered and enabled throughout, no data commit -> codes hold
    p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && en_q && buf_q && $past(en_q && buf_q)
         && !$past(bus_rd && int'(bus_addr) == ADR_DATA_UPD))
        |-> $stable(dac_code_o));

    // R4: direct-mode write to channel A is visible one clock later
    p_direct_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && en_q && !buf_q && bus_wr && int'(bus_addr) == ADR_DATA_BASE) && en_q)
        |-> dac_code_o[CW-1:0] == $past(bus_wdata[CW-1:0]));

    // R6: range outputs move only after a range-update read
    p_range_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd && int'(bus_addr) == ADR_RANGE))
        |-> ($stable(dac_bipolar_o) && $stable(dac_gain_o)));

    // R8: writing a mode word with enable clear zeroes every code
    p_disable_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_wr && int'(bus_addr) == ADR_MODE && !bus_wdata[MODE_EN_BIT])
        |-> dac_code_o == '0);
endmodule

bind dac_shadow_bank dacbank_chk #(.NCH(NCH), .CW(CW), .BW(BW), .AW(AW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .dac_code_o    (dac_code_o),
    .dac_bipolar_o (dac_bipolar_o),
    .dac_gain_o    (dac_gain_o),
    .en_q          (en_q),
    .buf_q         (buf_q)
);

// File: tb/test_dac_shadow_bank.sv
`timescale 1ns/1ps
// Bench: table-driven walk through modes and strobes, then directed reset tests.
module test_dac_shadow_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [47:0] dac_code_o;
    logic [3:0]  dac_bipolar_o;
    logic [3:0]  dac_gain_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dac_shadow_bank i_dac_shadow_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dac_code_o(dac_code_o),
        .dac_bipolar_o(dac_bipolar_o), .dac_gain_o(dac_gain_o)
    );

    // Vector: op[81:80] (1 write, 2 read), addr[79:76], wdata[75:60],
    // expected code[59:12], bipolar[11:8], gain[7:4], requirement[3:0]
    localparam int NV = 20;
    localparam logic [81:0] VECS [NV] = '{
        {2'd1, 4'd0, 16'h0003, 48'h0, 4'h0, 4'h0, 4'd9},                                  // R9 mode enabled+buffered
        {2'd1, 4'd4, 16'h0123, 48'h0, 4'h0, 4'h0, 4'd2},                                  // R2
        {2'd1, 4'd5, 16'h0456, 48'h0, 4'h0, 4'h0, 4'd2},                                  // R2
        {2'd1, 4'd6, 16'hF789, 48'h0, 4'h0, 4'h0, 4'd2},                                  // R2
        {2'd1, 4'd7, 16'h0ABC, 48'h0, 4'h0, 4'h0, 4'd2},                                  // R2
        {2'd2, 4'd2, 16'h0000, {12'hABC,12'h789,12'h456,12'h123}, 4'h0, 4'h0, 4'd3},      // R3 all four at once
        {2'd1, 4'd4, 16'h0FFF, {12'hABC,12'h789,12'h456,12'h123}, 4'h0, 4'h0, 4'd2},      // R2
        {2'd1, 4'd1, 16'h0A50, {12'hABC,12'h789,12'h456,12'h123}, 4'h0, 4'h0, 4'd6},      // R6 shadow only
        {2'd2, 4'd2, 16'h0000, {12'hABC,12'h789,12'h456,12'hFFF}, 4'h0, 4'h0, 4'd6},      // R6 data commit leaves range
        {2'd2, 4'd1, 16'h0000, {12'hABC,12'h789,12'h456,12'hFFF}, 4'hA, 4'h5, 4'd7},      // R7 decode
        {2'd1, 4'd0, 16'h0002, {12'hABC,12'h789,12'h456,12'hFFF}, 4'hA, 4'h5, 4'd9},      // R9 direct mode
        {2'd1, 4'd5, 16'hABCD, {12'hABC,12'h789,12'hBCD,12'hFFF}, 4'hA, 4'h5, 4'd4},      // R4 only channel B
        {2'd1, 4'd0, 16'h0000, 48'h0, 4'hA, 4'h5, 4'd8},                                  // R8 disabled
        {2'd1, 4'd7, 16'h0111, 48'h0, 4'hA, 4'h5, 4'd8},                                  // R8 write while disabled
        {2'd1, 4'd0, 16'h0002, {12'h111,12'h789,12'hBCD,12'hFFF}, 4'hA, 4'h5, 4'd8},      // R8 codes return
        {2'd1, 4'd1, 16'h0F00, {12'h111,12'h789,12'hBCD,12'hFFF}, 4'hA, 4'h5, 4'd6},      // R6 direct mode still waits
        {2'd2, 4'd1, 16'h0000, {12'h111,12'h789,12'hBCD,12'hFFF}, 4'h0, 4'hF, 4'd7},      // R7
        {2'd1, 4'd0, 16'h0003, {12'h111,12'h789,12'hBCD,12'hFFF}, 4'h0, 4'hF, 4'd9},      // R9
        {2'd1, 4'd6, 16'hF222, {12'h111,12'h789,12'hBCD,12'hFFF}, 4'h0, 4'hF, 4'd2},      // R2
        {2'd2, 4'd2, 16'h0000, {12'h111,12'h222,12'hBCD,12'hFFF}, 4'h0, 4'hF, 4'd5}       // R5 top nibble dropped
    };

    task automatic check(input int req, input string what, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic [1:0] op, input logic [3:0] a, input logic [15:0] d);
        bus_wr    = (op == 2'd1);
        bus_rd    = (op == 2'd2);
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic check_all(input int req, input logic [47:0] c, input logic [3:0] b, input logic [3:0] g);
        check(req, "code", dac_code_o, c);
        check(req, "bipolar", {44'h0, dac_bipolar_o}, {44'h0, b});
        check(req, "gain", {44'h0, dac_gain_o}, {44'h0, g});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_all(1, 48'h0, 4'h0, 4'h0);                // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            logic [81:0] v;
            v = VECS[k];
            bus_op(v[81:80], v[79:76], v[75:60]);
            check_all(int'(v[3:0]), v[59:12], v[11:8], v[7:4]);
        end
        // R1: mid-run reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check_all(1, 48'h0, 4'h0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no stale shadow survives into a later commit
        bus_op(2'd1, 4'd0, 16'h0003);
        bus_op(2'd2, 4'd2, 16'h0000);
        bus_op(2'd2, 4'd1, 16'h0000);
        check_all(1, 48'h0, 4'h0, 4'h0);
        // R4: direct write lands one clock later, neighbours untouched
        bus_op(2'd1, 4'd0, 16'h0002);
        bus_op(2'd1, 4'd7, 16'h0FED);
        check(4, "direct D", dac_code_o, {12'hFED, 36'h0});
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule